// File: doc/BRIEF.md
# Write-only I2C command/data receiver for a character display

This block is a receive-only I2C target that sits in front of a character display controller. It runs on a system clock much faster than SCL. Both bus lines are brought into that clock domain and watched for edges, START and STOP. The block answers to a 7-bit address. The top five bits are fixed at `01111` and the low two come from strap pins, so four of these blocks can share one bus at addresses 0x3C to 0x3F. The acknowledge is not driven onto SDA itself. It goes out on a separate pull-down request line, which the pad logic turns into an open-drain drive.

After the address, the host sends one or more control bytes, each followed by a payload. In a control byte, bit 7 is a continuation flag and bit 6 picks the destination. While the continuation flag is set, the control byte and its single payload byte alternate. A control byte with the flag cleared ends that pattern, and every later byte up to STOP is payload. Each payload byte leaves the block as a one-cycle strobe together with the byte and a tag. The tag tells the display controller whether the byte is an instruction or display RAM data.

Top module: `i2c_display_sink`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits (sent first) equal `01111` followed by `addr_pins_i[1]` and `addr_pins_i[0]`, and its eighth bit (read/write, 0 = write) is 0.
- R2: If the address mismatches or the read/write bit is 1, no byte of that transfer is acknowledged and no payload strobe fires, until the next START.
- R3: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are detected. After STOP the acknowledge request is low and no strobe fires until a new START.
- R4: A control byte with bit 7 = 1 is followed by exactly one payload byte, and the byte after that is again treated as a control byte. Control bytes are never strobed out.
- R5: After a control byte with bit 7 = 0, every further byte up to STOP is payload, including bytes whose value looks like a control byte.
- R6: Bit 6 of the latest control byte tags each payload byte: 0 gives `out_is_ram_o` = 0 (instruction), 1 gives `out_is_ram_o` = 1 (display RAM).
- R7: For each acknowledged byte, `ack_pull_o` is high from the falling SCL edge after the eighth bit until the falling edge of the ninth clock. It is high at no other time.
- R8: Bytes are assembled MSB first. `out_valid_o` is high for exactly one system clock per payload byte, with `out_byte_o` and `out_is_ram_o` valid in that cycle.
- R9: A repeated START or a STOP in the middle of a byte discards the partial byte and returns the block to address matching.
- R10: After reset, `ack_pull_o` and `out_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | 2 | Low two bits of the target address |
| ack_pull_o | output | 1 | High requests SDA to be pulled low (acknowledge) |
| out_valid_o | output | 1 | One-cycle strobe for a received payload byte |
| out_byte_o | output | 8 | Payload byte |
| out_is_ram_o | output | 1 | 1 = display RAM data, 0 = instruction |

## Verification
The assertions assume that SCL and SDA each stay stable for at least the synchronizer depth plus one system clock between changes. They also assume SDA changes only while SCL is low, except when the host forms a START or STOP. Under these assumptions no sampled cycle shows an SCL edge together with a START or STOP, and the one-cycle strobe cannot repeat. The bench bit-bangs the bus with each quarter SCL period lasting four system clocks. It sets SDA only in the low phase, and makes the partial-byte aborts out of ordinary bit slots followed by a START or STOP.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BITS = 2'd1,
        PH_ACK  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_CTRL = 2'd1,
        K_DATA = 2'd2
    } kind_e;

endpackage

// File: rtl/dsl_line_sampler.sv
module dsl_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t q, d;
    logic scl_now, sda_now;

    assign scl_now = q.scl_sh[SYNC_STAGES-1];
    assign sda_now = q.sda_sh[SYNC_STAGES-1];

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[SYNC_STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = scl_now;
        d.sda_prev = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_o      = sda_now;
    assign scl_rise_o = !q.scl_prev && scl_now;
    assign scl_fall_o = q.scl_prev && !scl_now;
    assign start_o    = q.scl_prev && scl_now && q.sda_prev && !sda_now;
    assign stop_o     = q.scl_prev && scl_now && !q.sda_prev && sda_now;

    // R3: bus events are mutually exclusive in any sampled cycle
    assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

endmodule

// File: rtl/dsl_link_fsm.sv
module dsl_link_fsm
    import dsl_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 7,
    parameter int PIN_W  = 2,
    parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI = 5'b01111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [PIN_W-1:0]  pins_i,
    output logic              ack_o,
    output logic              valid_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_ram_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam int CO_BIT = BYTE_W - 1;
    localparam int RS_BIT = BYTE_W - 2;

    typedef struct packed {
        phase_e             phase;
        kind_e              kind;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               take;
        logic               ack;
        logic               stream;
        logic               rs;
        logic               vld;
        logic [BYTE_W-1:0]  dout;
        logic               dram;
    } lk_t;

    lk_t q, d;
    logic [BYTE_W-1:0] nb;
    kind_e             next_kind;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        nb    = {q.sh[BYTE_W-2:0], sda_i};
        case (q.kind)
            K_ADDR:  next_kind = K_CTRL;
            K_CTRL:  next_kind = K_DATA;
            default: next_kind = q.stream ? K_DATA : K_CTRL;
        endcase

        if (start_i) begin
            d.phase  = PH_BITS;
            d.kind   = K_ADDR;
            d.cnt    = '0;
            d.ack    = 1'b0;
            d.take   = 1'b0;
            d.stream = 1'b0;
        end else if (stop_i) begin
            d.phase = PH_IDLE;
            d.ack   = 1'b0;
            d.cnt   = '0;
        end else begin
            case (q.phase)
                PH_BITS: begin
                    if (scl_rise_i && q.cnt != CNT_FULL) begin
                        d.sh  = nb;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_LAST) begin
                            case (q.kind)
                                K_ADDR: d.take = (nb[BYTE_W-1 -: ADDR_W] == {ADDR_HI, pins_i})
                                                 && !nb[0];
                                K_CTRL: begin
                                    d.take   = 1'b1;
                                    d.rs     = nb[RS_BIT];
                                    d.stream = !nb[CO_BIT];
                                end
                                default: begin
                                    d.take = 1'b1;
                                    d.vld  = 1'b1;
                                    d.dout = nb;
                                    d.dram = q.rs;
                                end
                            endcase
                        end
                    end else if (scl_fall_i && q.cnt == CNT_FULL) begin
                        d.phase = PH_ACK;
                        d.ack   = q.take;
                    end
                end
                PH_ACK: begin
                    if (scl_fall_i) begin
                        d.ack   = 1'b0;
                        d.cnt   = '0;
                        d.phase = q.take ? PH_BITS : PH_IDLE;
                        d.kind  = next_kind;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_o    = q.ack;
    assign valid_o  = q.vld;
    assign byte_o   = q.dout;
    assign is_ram_o = q.dram;

    // R8: payload strobe never lasts two cycles
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: acknowledge request only inside the ninth-clock slot
    assert_ack_in_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> q.phase == PH_ACK);

    // R3: STOP idles the receiver and drops the acknowledge
    assert_stop_idles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.phase == PH_IDLE && !ack_o));

    // R9: START rearms address matching with an empty bit count
    assert_start_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.phase == PH_BITS && q.kind == K_ADDR && q.cnt == '0));

    // R5: a strobe only follows a byte received in payload position
    assert_strobe_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(q.kind == K_DATA && q.phase == PH_BITS));

endmodule

// File: rtl/i2c_display_sink.sv
module i2c_display_sink #(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int ADDR_W      = 7,
    parameter int PIN_W       = 2,
    parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI = 5'b01111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [PIN_W-1:0]  addr_pins_i,
    output logic              ack_pull_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_is_ram_o
);

    logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    dsl_line_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    dsl_link_fsm #(
        .BYTE_W  (BYTE_W),
        .ADDR_W  (ADDR_W),
        .PIN_W   (PIN_W),
        .ADDR_HI (ADDR_HI)
    ) u_lnk (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_i      (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .pins_i     (addr_pins_i),
        .ack_o      (ack_pull_o),
        .valid_o    (out_valid_o),
        .byte_o     (out_byte_o),
        .is_ram_o   (out_is_ram_o)
    );

endmodule

// File: tb/test_i2c_display_sink.sv
module test_i2c_display_sink;

    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [1:0] pins = 2'b00;
    logic       ack_pull;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_is_ram;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_b [256];
    logic       exp_r [256];
    int         ne = 0;
    logic [7:0] act_b [256];
    logic       act_r [256];
    int         na = 0;
    logic       prev_valid = 1'b0;

    always #10 clk = ~clk;

    i2c_display_sink i_i2c_display_sink (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda),
        .addr_pins_i  (pins),
        .ack_pull_o   (ack_pull),
        .out_valid_o  (out_valid),
        .out_byte_o   (out_byte),
        .out_is_ram_o (out_is_ram)
    );

    // Collects strobes; R8 single-cycle strobe check
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && prev_valid) begin
                errors++;
                $display("FAIL R8 strobe held two cycles: actual 1 expected 0");
            end
            if (out_valid && na < 256) begin
                act_b[na] = out_byte;
                act_r[na] = out_is_ram;
                na++;
            end
            prev_valid = out_valid;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda = b; wq(Q);
        scl = 1'b1; wq(2 * Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop(input string req);
        sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        sda = 1'b1; wq(2 * Q);
        chk(ack_pull == 1'b0, req, int'(ack_pull), 0);
    endtask

    // Eight bits MSB first, then the ninth clock with acknowledge sampled mid-high
    task automatic byte_out(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        chk(ack_pull == exp_ack, req, int'(ack_pull), int'(exp_ack));
        wq(Q);
        scl = 1'b0; wq(Q);
        chk(ack_pull == 1'b0, "R7 release", int'(ack_pull), 0);
    endtask

    task automatic expect_byte(input logic [7:0] b, input logic r);
        exp_b[ne] = b;
        exp_r[ne] = r;
        ne++;
    endtask

    function automatic bit addr_hit(input logic [6:0] a, input logic rw, input logic [1:0] p);
        return (a == {5'b01111, p}) && !rw;
    endfunction

    task automatic compare(input string req);
        chk(na == ne, {req, " count"}, na, ne);
        for (int i = 0; i < ne && i < na; i++) begin
            chk(act_b[i] == exp_b[i], {req, " byte"}, int'(act_b[i]), int'(exp_b[i]));
            chk(act_r[i] == exp_r[i], "R6 tag", int'(act_r[i]), int'(exp_r[i]));
        end
        na = 0;
        ne = 0;
    endtask

    task automatic random_txn();
        logic [6:0] a;
        logic       rw;
        logic       rs;
        logic [7:0] dv;
        bit         hit;
        int         npair;
        int         nstream;
        pins = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 9) < 7) a = {5'b01111, pins};
        else                          a = 7'($urandom_range(0, 127));
        rw  = ($urandom_range(0, 9) < 2);
        hit = addr_hit(a, rw, pins);
        bus_start();
        byte_out({a, rw}, hit, "R1/R2 address");
        npair = $urandom_range(0, 3);
        for (int k = 0; k < npair; k++) begin
            rs = 1'($urandom_range(0, 1));
            byte_out({1'b1, rs, 6'b0}, hit, "R4 control");
            dv = 8'($urandom_range(0, 255));
            byte_out(dv, hit, "R4 payload");
            if (hit) expect_byte(dv, rs);
        end
        if ($urandom_range(0, 9) < 7) begin
            rs = 1'($urandom_range(0, 1));
            byte_out({1'b0, rs, 6'b0}, hit, "R5 last control");
            nstream = $urandom_range(0, 6);
            for (int k = 0; k < nstream; k++) begin
                dv = 8'($urandom_range(0, 255));
                byte_out(dv, hit, "R5 stream");
                if (hit) expect_byte(dv, rs);
            end
        end
        bus_stop("R3 stop");
        wq(4);
        compare("R5/R8 random");
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        wq(3);
        chk(ack_pull == 1'b0, "R10 ack reset", int'(ack_pull), 0);
        chk(out_valid == 1'b0, "R10 valid reset", int'(out_valid), 0);
        rst_n = 1'b1;
        wq(4);

        // R1: matching address with pins 10, then a neighbour that must be refused
        pins = 2'b10;
        bus_start();
        byte_out({7'h3E, 1'b0}, 1'b1, "R1 match 0x3E");
        bus_stop("R3 stop");
        bus_start();
        byte_out({7'h3D, 1'b0}, 1'b0, "R1 mismatch 0x3D");
        byte_out(8'h00, 1'b0, "R2 no ack after mismatch");
        byte_out(8'h55, 1'b0, "R2 no ack after mismatch");
        bus_stop("R3 stop");
        compare("R2 mismatch silent");

        // R2: read request refused, payload-like bytes ignored
        pins = 2'b01;
        bus_start();
        byte_out({7'h3D, 1'b1}, 1'b0, "R2 read refused");
        byte_out(8'h40, 1'b0, "R2 no ack after read");
        byte_out(8'hA5, 1'b0, "R2 no ack after read");
        bus_stop("R3 stop");
        compare("R2 read silent");

        // R4/R6/R8: alternating control and payload, MSB-first values
        pins = 2'b00;
        bus_start();
        byte_out({7'h3C, 1'b0}, 1'b1, "R1 match 0x3C");
        byte_out(8'h80, 1'b1, "R4 control rs0");
        byte_out(8'h01, 1'b1, "R4 payload");
        expect_byte(8'h01, 1'b0);
        byte_out(8'hC0, 1'b1, "R4 control rs1");
        byte_out(8'h80, 1'b1, "R4 payload");
        expect_byte(8'h80, 1'b1);
        byte_out(8'h80, 1'b1, "R4 back to control");
        byte_out(8'h81, 1'b1, "R4 payload");
        expect_byte(8'h81, 1'b0);
        bus_stop("R3 stop");
        compare("R4 alternation");

        // R5: stream bytes that look like control bytes are payload
        pins = 2'b11;
        bus_start();
        byte_out({7'h3F, 1'b0}, 1'b1, "R1 match 0x3F");
        byte_out(8'h40, 1'b1, "R5 last control rs1");
        byte_out(8'h80, 1'b1, "R5 stream");
        expect_byte(8'h80, 1'b1);
        byte_out(8'hC0, 1'b1, "R5 stream");
        expect_byte(8'hC0, 1'b1);
        byte_out(8'h00, 1'b1, "R5 stream");
        expect_byte(8'h00, 1'b1);
        bus_stop("R3 stop");
        compare("R5 stream");

        // R9: STOP mid-byte discards the partial byte
        pins = 2'b00;
        bus_start();
        byte_out({7'h3C, 1'b0}, 1'b1, "R1 match");
        byte_out(8'h00, 1'b1, "R5 last control rs0");
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        bus_stop("R9 stop mid-byte");
        wq(4);
        compare("R9 stop discard");
        chk(out_valid == 1'b0, "R3 idle after stop", int'(out_valid), 0);

        // R9: repeated START mid-byte, then a clean transfer
        bus_start();
        byte_out({7'h3C, 1'b0}, 1'b1, "R1 match");
        byte_out(8'h40, 1'b1, "R5 last control rs1");
        for (int i = 0; i < 5; i++) bit_out(1'b0);
        bus_start();
        byte_out({7'h3C, 1'b0}, 1'b1, "R9 address after restart");
        byte_out(8'h80, 1'b1, "R9 control after restart");
        byte_out(8'h3A, 1'b1, "R9 payload after restart");
        expect_byte(8'h3A, 1'b0);
        bus_stop("R3 stop");
        compare("R9 restart");

        for (int t = 0; t < 40; t++) random_txn();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule